// File: doc/BRIEF.md
# Multiplayer Host Transfer Sequencer

This block paces one host-side multiplayer radio exchange against a one-microsecond tick. A start strobe captures the transfer settings. The sequencer then walks through a fixed chain of timed phases: a preamble, the host data frame, a window in which the clients may reply, and a short acknowledge frame. At the phase boundaries it raises interrupt pulses. Throughout, it reports a radio status code that reflects what the radio front end is doing.

The length of the reply window depends on how many clients are addressed. The block counts the set bits of the 16-bit client mask and scales that count by a per-client time. The per-client time is the programmed reply time plus a fixed overhead. When the data frame starts, the block publishes the frame's sequence-control word, which is the sequence number moved up past the four fragment bits. A one-cycle done strobe marks the return to idle.

Top module: `mp_host_seq`

## Requirements
- R1: After reset, `rf_status` reads 9 (idle), `seq_field` is 0, and `irq_start`, `irq_txend`, `irq_mp_end` and `done` are low.
- R2: A `start` pulse while idle moves `rf_status` to 3 on the next cycle and captures `slot`, `data_len`, `tx_rate`, `client_mask`, `reply_time`, `seq_num` and `txend_irq_en`. Later changes to these inputs, and any `start` while busy, do not alter the run in progress.
- R3: The preamble lasts `PRE_US` ticks (default 96), with `rf_status` = 3.
- R4: When the preamble ends, `irq_start` pulses for one cycle unless the captured slot equals 5. From that cycle on, `seq_field` equals the captured `seq_num` shifted left by 4.
- R5: The data phase lasts `data_len`×8 ticks when `tx_rate`=0 (1 Mbps), or `data_len`×4 ticks when `tx_rate`=1 (2 Mbps). A length of 0 gives 1 tick. `rf_status` stays 3 during this phase.
- R6: When the data phase ends, `rf_status` becomes 5 and `irq_txend` pulses for one cycle if the captured `txend_irq_en` is 1.
- R7: The reply window lasts 112 + (10 + `reply_time`) × N ticks, where N is the number of set bits in the captured `client_mask`.
- R8: When the reply window ends, `irq_start` pulses for one cycle whatever the slot, and `rf_status` becomes 8 for the acknowledge, which lasts `ACK_BYTES`×8 ticks (16 bytes at 1 Mbps = 128).
- R9: When the acknowledge ends, the following happen in one cycle:
  - `rf_status` returns to 9.
  - `done` pulses for one cycle.
  - `irq_txend` pulses if the captured `txend_irq_en` is 1.
  - `irq_mp_end` pulses exactly when `xfer_ok` or `no_retry_time` is 1 at that edge.
- R10: Phase timers advance only on cycles with `us_tick` high. `rf_status` only ever holds 3, 5, 8 or 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond tick |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| slot | input | 3 | Transmit slot number |
| data_len | input | 12 | Data frame length in bytes |
| tx_rate | input | 1 | 0 = 1 Mbps, 1 = 2 Mbps |
| client_mask | input | 16 | One bit per addressed client |
| reply_time | input | 8 | Per-client reply time in microseconds |
| seq_num | input | 12 | Frame sequence number |
| txend_irq_en | input | 1 | Enable the optional end-of-transmit interrupt |
| xfer_ok | input | 1 | All replies received (sampled at acknowledge end) |
| no_retry_time | input | 1 | No time left to retry (sampled at acknowledge end) |
| irq_start | output | 1 | Transmit-start interrupt pulse |
| irq_txend | output | 1 | End-of-transmit interrupt pulse |
| irq_mp_end | output | 1 | Transfer-complete interrupt pulse |
| rf_status | output | 4 | Radio status code |
| seq_field | output | 16 | Sequence-control word for the frame |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
A phase counter that is loaded wrongly or decrements wrongly shows up at the ports as a status change or interrupt pulse that comes one or more ticks early or late. It is visible at the very phase boundary where the count should have ended. A wrong popcount or reply arithmetic moves the 5-to-8 status change by a multiple of the per-client time, so a sweep over every client count from 0 to 16 exposes it. A phase decode error shows as a wrong status code or a missing or extra interrupt pulse on the cycle right after the boundary.

// File: rtl/mp_seq_pkg.sv
package mp_seq_pkg;

    localparam int MP_SLOT_W  = 3;
    localparam int MP_LEN_W   = 12;
    localparam int MP_MASK_W  = 16;
    localparam int MP_RT_W    = 8;
    localparam int MP_SEQ_W   = 12;
    localparam int MP_FRAG_W  = 4;
    localparam int MP_RF_W    = 4;
    localparam int MP_CNT_W   = $clog2(MP_MASK_W + 1);

    localparam int REPLY_BASE_US = 112;
    localparam int REPLY_PER_US  = 10;

    localparam logic [MP_RF_W-1:0] RF_TX   = 4'd3;
    localparam logic [MP_RF_W-1:0] RF_WAIT = 4'd5;
    localparam logic [MP_RF_W-1:0] RF_ACK  = 4'd8;
    localparam logic [MP_RF_W-1:0] RF_IDLE = 4'd9;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_DATA  = 3'd2,
        PH_REPLY = 3'd3,
        PH_ACK   = 3'd4
    } mp_phase_e;

    typedef struct packed {
        logic [MP_SLOT_W-1:0] slot;
        logic [MP_LEN_W-1:0]  len;
        logic                 rate;
        logic [MP_MASK_W-1:0] mask;
        logic [MP_RT_W-1:0]   reply_time;
        logic [MP_SEQ_W-1:0]  seq;
        logic                 txend_en;
    } mp_cfg_t;

    function automatic logic [MP_RF_W-1:0] rf_code(input mp_phase_e ph);
        case (ph)
            PH_PRE, PH_DATA: rf_code = RF_TX;
            PH_REPLY:        rf_code = RF_WAIT;
            PH_ACK:          rf_code = RF_ACK;
            default:         rf_code = RF_IDLE;
        endcase
    endfunction

    function automatic logic [MP_SEQ_W+MP_FRAG_W-1:0] seq_word(input logic [MP_SEQ_W-1:0] s);
        seq_word = {s, {MP_FRAG_W{1'b0}}};
    endfunction

endpackage

// File: rtl/mp_seq_popcnt.sv
module mp_seq_popcnt #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    logic [CW-1:0] part [W+1];

    assign part[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_sum
        assign part[i+1] = part[i] + CW'(bits[i]);
    end

    assign count = part[W];
endmodule

// File: rtl/mp_seq_dur.sv
module mp_seq_dur
    import mp_seq_pkg::*;
#(
    parameter int PRE_US    = 96,
    parameter int ACK_BYTES = 16,
    parameter int CNT_W     = 16
) (
    input  mp_phase_e             phase,
    input  logic [MP_LEN_W-1:0]   len,
    input  logic                  rate,
    input  logic [MP_MASK_W-1:0]  mask,
    input  logic [MP_RT_W-1:0]    reply_time,
    output logic [CNT_W-1:0]      ticks
);
    localparam int ACK_US = ACK_BYTES * 8;

    logic [MP_CNT_W-1:0] n_clients;
    logic [CNT_W-1:0]    n_w, rt_w, len_w, reply_t, data_t;

    mp_seq_popcnt #(.W(MP_MASK_W), .CW(MP_CNT_W)) u_pop (
        .bits  (mask),
        .count (n_clients)
    );

    always_comb begin
        n_w     = CNT_W'(n_clients);
        rt_w    = CNT_W'(reply_time);
        len_w   = CNT_W'(len);
        reply_t = CNT_W'(REPLY_BASE_US) + (CNT_W'(REPLY_PER_US) + rt_w) * n_w;
        if (len == '0)
            data_t = CNT_W'(1);
        else if (rate)
            data_t = len_w << 2;
        else
            data_t = len_w << 3;
    end

    always_comb begin
        case (phase)
            PH_PRE:   ticks = CNT_W'(PRE_US);
            PH_DATA:  ticks = data_t;
            PH_REPLY: ticks = reply_t;
            PH_ACK:   ticks = CNT_W'(ACK_US);
            default:  ticks = '0;
        endcase
    end
endmodule

// File: rtl/mp_seq_timer.sv
module mp_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expire = tick && (cnt == CNT_W'(1));
endmodule

// File: rtl/mp_host_seq.sv
module mp_host_seq
    import mp_seq_pkg::*;
#(
    parameter int PRE_US     = 96,
    parameter int ACK_BYTES  = 16,
    parameter int CNT_W      = 16,
    parameter int QUIET_SLOT = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          us_tick,
    input  logic                          start,
    input  logic [MP_SLOT_W-1:0]          slot,
    input  logic [MP_LEN_W-1:0]           data_len,
    input  logic                          tx_rate,
    input  logic [MP_MASK_W-1:0]          client_mask,
    input  logic [MP_RT_W-1:0]            reply_time,
    input  logic [MP_SEQ_W-1:0]           seq_num,
    input  logic                          txend_irq_en,
    input  logic                          xfer_ok,
    input  logic                          no_retry_time,
    output logic                          irq_start,
    output logic                          irq_txend,
    output logic                          irq_mp_end,
    output logic [MP_RF_W-1:0]            rf_status,
    output logic [MP_SEQ_W+MP_FRAG_W-1:0] seq_field,
    output logic                          done
);
    mp_phase_e        phase, nxt;
    mp_cfg_t          cfg_q;
    logic             accept, expire, load;
    logic [CNT_W-1:0] dur;

    assign accept = start && (phase == PH_IDLE);

    always_comb begin
        nxt = phase;
        if (accept)
            nxt = PH_PRE;
        else if (expire) begin
            case (phase)
                PH_PRE:   nxt = PH_DATA;
                PH_DATA:  nxt = PH_REPLY;
                PH_REPLY: nxt = PH_ACK;
                PH_ACK:   nxt = PH_IDLE;
                default:  nxt = PH_IDLE;
            endcase
        end
    end

    assign load = accept || expire;

    mp_seq_dur #(.PRE_US(PRE_US), .ACK_BYTES(ACK_BYTES), .CNT_W(CNT_W)) u_dur (
        .phase      (nxt),
        .len        (cfg_q.len),
        .rate       (cfg_q.rate),
        .mask       (cfg_q.mask),
        .reply_time (cfg_q.reply_time),
        .ticks      (dur)
    );

    mp_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (us_tick),
        .load     (load),
        .load_val (dur),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cfg_q      <= '0;
            irq_start  <= 1'b0;
            irq_txend  <= 1'b0;
            irq_mp_end <= 1'b0;
            done       <= 1'b0;
            seq_field  <= '0;
            rf_status  <= RF_IDLE;
        end else begin
            phase      <= nxt;
            rf_status  <= rf_code(nxt);
            irq_start  <= 1'b0;
            irq_txend  <= 1'b0;
            irq_mp_end <= 1'b0;
            done       <= 1'b0;
            if (accept) begin
                cfg_q.slot       <= slot;
                cfg_q.len        <= data_len;
                cfg_q.rate       <= tx_rate;
                cfg_q.mask       <= client_mask;
                cfg_q.reply_time <= reply_time;
                cfg_q.seq        <= seq_num;
                cfg_q.txend_en   <= txend_irq_en;
            end
            if (expire) begin
                case (phase)
                    PH_PRE: begin
                        irq_start <= (cfg_q.slot != MP_SLOT_W'(QUIET_SLOT));
                        seq_field <= seq_word(cfg_q.seq);
                    end
                    PH_DATA:  irq_txend <= cfg_q.txend_en;
                    PH_REPLY: irq_start <= 1'b1;
                    PH_ACK: begin
                        irq_txend  <= cfg_q.txend_en;
                        irq_mp_end <= xfer_ok || no_retry_time;
                        done       <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mp_host_seq_chk.sv
module mp_host_seq_chk
    import mp_seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               us_tick,
    input logic               start,
    input logic               irq_start,
    input logic               irq_mp_end,
    input logic [MP_RF_W-1:0] rf_status,
    input logic               done
);
    assert_code_set_R10: assert property (@(posedge clk) disable iff (rst)
        rf_status == RF_TX || rf_status == RF_WAIT || rf_status == RF_ACK || rf_status == RF_IDLE);

    assert_tick_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (!us_tick && !start) |=> $stable(rf_status));

    assert_start_enter_R2: assert property (@(posedge clk) disable iff (rst)
        (start && rf_status == RF_IDLE) |=> rf_status == RF_TX);

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        irq_start |=> !irq_start);

    assert_ack_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (rf_status == RF_ACK && $past(rf_status) == RF_WAIT) |-> irq_start);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> rf_status == RF_IDLE);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_mpend_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        irq_mp_end |-> done);
endmodule

bind mp_host_seq mp_host_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .us_tick    (us_tick),
    .start      (start),
    .irq_start  (irq_start),
    .irq_mp_end (irq_mp_end),
    .rf_status  (rf_status),
    .done       (done)
);

// File: tb/mp_host_seq_bench.sv
`timescale 1ns/1ps
module mp_host_seq_bench;
    localparam int PRE = 96;
    localparam int ACK = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        us_tick = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  slot = '0;
    logic [11:0] data_len = '0;
    logic        tx_rate = 1'b0;
    logic [15:0] client_mask = '0;
    logic [7:0]  reply_time = '0;
    logic [11:0] seq_num = '0;
    logic        txend_irq_en = 1'b0;
    logic        xfer_ok = 1'b0;
    logic        no_retry_time = 1'b0;
    logic        irq_start, irq_txend, irq_mp_end, done;
    logic [3:0]  rf_status;
    logic [15:0] seq_field;

    int tests = 0;
    int fails = 0;
    int div = 1;

    always #4 clk = ~clk;

    mp_host_seq u_mp_host_seq (
        .clk(clk), .rst(rst), .us_tick(us_tick), .start(start), .slot(slot),
        .data_len(data_len), .tx_rate(tx_rate), .client_mask(client_mask),
        .reply_time(reply_time), .seq_num(seq_num), .txend_irq_en(txend_irq_en),
        .xfer_ok(xfer_ok), .no_retry_time(no_retry_time), .irq_start(irq_start),
        .irq_txend(irq_txend), .irq_mp_end(irq_mp_end), .rf_status(rf_status),
        .seq_field(seq_field), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drives ticks until L ticks have been applied; checks steady state before, the boundary after.
    task automatic walk(input int L, input logic [3:0] st_in, input logic [3:0] st_out,
                        input logic [2:0] irq_exp, input logic done_exp,
                        input bit poke, input string req);
        int  ticks = 0;
        int  k = 0;
        bit  good = 1'b1;
        int  bad_st = 0;
        if (poke) start = 1'b1;
        forever begin
            us_tick = ((k % div) == 0);
            k++;
            @(negedge clk);
            if (us_tick) ticks++;
            if (ticks == L) break;
            if (rf_status != st_in || {irq_start, irq_txend, irq_mp_end} != 3'b000 || done) begin
                if (good) bad_st = int'(rf_status);
                good = 1'b0;
            end
        end
        us_tick = 1'b0;
        start = 1'b0;
        chk(good, req, "status held and no pulse inside phase", bad_st, int'(st_in));
        chk(rf_status == st_out, req, "status after phase end", int'(rf_status), int'(st_out));
        chk({irq_start, irq_txend, irq_mp_end} == irq_exp, req, "interrupt pulses at phase end",
            int'({irq_start, irq_txend, irq_mp_end}), int'(irq_exp));
        chk(done == done_exp, req, "done at phase end", int'(done), int'(done_exp));
    endtask

    task automatic run_xfer(input logic [15:0] m, input int rt, input int len, input bit rate,
                            input int sl, input bit en, input bit ok, input bit nt,
                            input logic [11:0] sq, input bit scramble, input bit poke, input int stall);
        int dticks;
        int rticks;
        dticks = (len == 0) ? 1 : len * (rate ? 4 : 8);
        rticks = 112 + (10 + rt) * $countones(m);
        @(negedge clk);
        client_mask = m; reply_time = 8'(rt); data_len = 12'(len); tx_rate = rate;
        slot = 3'(sl); txend_irq_en = en; seq_num = sq;
        xfer_ok = ok; no_retry_time = nt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rf_status == 4'd3, "R2", "status after start", int'(rf_status), 3);
        if (scramble) begin
            // R2: captured settings must not follow later input changes
            client_mask = ~m; reply_time = ~8'(rt); data_len = 12'(len + 9);
            tx_rate = ~rate; slot = 3'(sl + 1); txend_irq_en = ~en; seq_num = ~sq;
        end
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
        end
        if (stall > 0)
            chk(rf_status == 4'd3 && !irq_start, "R10", "no progress without ticks", int'(rf_status), 3);
        walk(PRE, 4'd3, 4'd3, {sl != 5, 1'b0, 1'b0}, 1'b0, 1'b0, "R3_R4");
        chk(seq_field == {sq, 4'b0000}, "R4", "sequence word", int'(seq_field), int'({sq, 4'b0000}));
        walk(dticks, 4'd3, 4'd5, {1'b0, en, 1'b0}, 1'b0, 1'b0, "R5_R6");
        walk(rticks, 4'd5, 4'd8, 3'b100, 1'b0, poke, "R7");
        walk(ACK, 4'd8, 4'd9, {1'b0, en, ok | nt}, 1'b1, 1'b0, "R8_R9");
        @(negedge clk);
        chk(!done && {irq_start, irq_txend, irq_mp_end} == 3'b000 && rf_status == 4'd9,
            "R9", "single-cycle done and idle", int'(done), 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rf_status == 4'd9, "R1", "reset status", int'(rf_status), 9);
        chk(seq_field == 16'h0, "R1", "reset seq word", int'(seq_field), 0);
        chk({irq_start, irq_txend, irq_mp_end, done} == 4'b0, "R1", "reset pulses",
            int'({irq_start, irq_txend, irq_mp_end, done}), 0);

        // first run: stalled ticks, 2 Mbps
        div = 1;
        run_xfer(16'h0005, 3, 5, 1'b1, 0, 1'b1, 1'b1, 1'b0, 12'hABC, 1'b1, 1'b1, 20);

        // sweep every client count 0..16
        for (int n = 0; n <= 16; n++) begin
            logic [15:0] m;
            m = 16'((32'h1 << n) - 1);
            m = (m << (n % 3)) | (m >> (16 - (n % 3)));
            div = (n % 3 == 0) ? 3 : 1;
            run_xfer(m, (n * 7) % 11, 1 + (n * 5) % 23, n[0], n % 6, (n % 3) != 0,
                     n[0], (n % 4) == 3, 12'(n * 257), (n % 4) == 1, (n % 5) == 2, 0);
        end

        // largest window, zero length, quiet slot, no completion interrupt
        div = 1;
        run_xfer(16'hFFFF, 255, 0, 1'b0, 5, 1'b0, 1'b0, 1'b0, 12'hFFF, 1'b0, 1'b0, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule